// File: doc/BRIEF.md
# Timer-to-Raster Phase Aligner

This block keeps a periodic interval timer running and, on request, pulls the timer's tick into a fixed phase relation with the horizontal timing of a raster generator. One scanline lasts 76 clocks. After a start request the block checks the display-enable level at the first tick. If display is active there, it runs the timer one clock short (75) or one clock long (77) for each line. Each following tick then lands one position earlier or later on the line. The slide stops at the first tick that finds display enable low. At that point the timer is reloaded with its nominal period, plus an optional one-time offset.

Searching earlier stops at the end of horizontal blanking. Searching later stops at its start. The number of off-period ticks the search took is kept on an output, so software also learns how many scanlines went by. If no edge appears within 76 search ticks, the block gives up and raises a fault flag.

Top module: `raster_phase_lock`

## Requirements
- R1: After reset the locked and fault flags are 0, the line count is 0, and `tick_o` pulses for one cycle every 76 clocks.
- R2: A reload value takes effect only when the timer reaches its terminal count. A start pulse never shortens or stretches the interval already running, so the first tick after a start from idle, locked or fault state comes 76 clocks after the previous one.
- R3: The first tick after a start samples `de_i`. If it is 0, the start has no effect: the following interval is 76, and locked, fault and line count all stay 0.
- R4: With `dir_i` = 0 (search earlier), every search tick comes 75 clocks after the previous tick.
- R5: With `dir_i` = 1 (search later), every search tick comes 77 clocks after the previous tick.
- R6: At the first search tick that samples `de_i` = 0, the timer is reloaded. `locked_o` reads 1 in the cycle right after that tick and stays 0 before it. From the second interval after lock onward, ticks are 76 clocks apart.
- R7: At lock, `line_cnt_o` equals the number of ticks issued at the off-nominal period, counted from the first tick after the arming tick through the tick that found the edge.
- R8: The first interval after lock is 76 + `ofs_i`. `ofs_i` is an 8-bit two's complement value sampled at the lock tick, and the result is clamped to at least 2.
- R9: If 76 search ticks in a row all sample `de_i` = 1, `fault_o` reads 1 in the cycle after the 76th tick. At that point `line_cnt_o` is 76, `locked_o` is 0, and the next interval is 76.
- R10: `locked_o` and `fault_o` hold their value until reset or a new start. A start clears both, and they read 0 in the cycle after the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a new alignment |
| de_i | input | 1 | Display-enable level from the raster generator |
| dir_i | input | 1 | Search direction, latched at start: 0 earlier, 1 later |
| ofs_i | input | 8 | Signed one-time period offset applied after lock |
| tick_o | output | 1 | Timer terminal-count pulse |
| locked_o | output | 1 | Phase is aligned |
| fault_o | output | 1 | Search ran out without finding an edge |
| line_cnt_o | output | 7 | Off-period ticks issued during the search |

## Verification
A corrupted down-counter shows up as a tick interval that is not 75, 76 or 77. The bench measures every interval at the tick output, so the error is seen within one line. A wrong controller state shows up in one of three ways: a slip period applied with the wrong sign, a lock at the wrong tick, or a fault where an edge existed. Each of these is caught at the first tick where the raster model disagrees, because the bench predicts from the sampled start position exactly which tick must find the edge. A miscounted line count or a lost offset is caught one cycle, or one interval, after lock.

// File: rtl/rpl_pkg.sv
package rpl_pkg;

    // Nominal raster line length and search bound
    localparam int NOM_LINE   = 76;
    localparam int SEEK_LIMIT = 76;
    localparam int OFFSET_W   = 8;
    localparam int MIN_PERIOD = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SEEK,
        ST_LOCKED,
        ST_FAULT
    } seek_state_e;

    typedef struct packed {
        logic locked;
        logic fault;
    } seek_flags_t;

    // Off-nominal period used while sliding across the line
    function automatic int slip_period(input int nominal, input logic later);
        return later ? nominal + 1 : nominal - 1;
    endfunction

    // One-shot period after lock, clamped to a legal minimum
    function automatic int trimmed_period(input int nominal, input int ofs);
        int p;
        p = nominal + ofs;
        return (p < MIN_PERIOD) ? MIN_PERIOD : p;
    endfunction

endpackage

// File: rtl/rpl_interval_timer.sv
module rpl_interval_timer
    import rpl_pkg::*;
#(
    parameter int LINE_PERIOD = NOM_LINE,
    parameter int PER_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] load_i,
    output logic             tick_o
);

    logic [PER_W-1:0] cnt_q;

    assign tick_o = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= PER_W'(LINE_PERIOD - 1);
        end else if (tick_o) begin
            cnt_q <= load_i - PER_W'(1);
        end else begin
            cnt_q <= cnt_q - PER_W'(1);
        end
    end

    // Count only moves by one between terminal counts
    assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> (cnt_q == $past(cnt_q) - PER_W'(1)));

    // Reload value offered by the controller is never below the floor
    assert_load_floor_R8: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (load_i >= PER_W'(MIN_PERIOD)));

endmodule

// File: rtl/rpl_seek_ctrl.sv
module rpl_seek_ctrl
    import rpl_pkg::*;
#(
    parameter int LINE_PERIOD = NOM_LINE,
    parameter int MAX_SEARCH  = SEEK_LIMIT,
    parameter int OFS_W       = OFFSET_W,
    parameter int PER_W       = 8,
    parameter int CNT_W       = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    tick_i,
    input  logic                    de_i,
    input  logic                    dir_i,
    input  logic signed [OFS_W-1:0] ofs_i,
    output logic [PER_W-1:0]        next_period_o,
    output logic                    locked_o,
    output logic                    fault_o,
    output logic [CNT_W-1:0]        line_cnt_o
);

    localparam logic [PER_W-1:0] P_NOM   = PER_W'(LINE_PERIOD);
    localparam logic [PER_W-1:0] P_EARLY = PER_W'(slip_period(LINE_PERIOD, 1'b0));
    localparam logic [PER_W-1:0] P_LATE  = PER_W'(slip_period(LINE_PERIOD, 1'b1));
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(MAX_SEARCH - 1);

    seek_state_e      state_q, state_n;
    logic             dir_q;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [PER_W-1:0] slip_val, trim_val;
    seek_flags_t      flags;

    assign slip_val = dir_q ? P_LATE : P_EARLY;
    assign trim_val = PER_W'(trimmed_period(LINE_PERIOD, int'(ofs_i)));

    always_comb begin
        state_n       = state_q;
        cnt_n         = cnt_q;
        next_period_o = P_NOM;
        if (start_i) begin
            state_n = ST_ARM;
            cnt_n   = '0;
        end else if (tick_i) begin
            case (state_q)
                ST_ARM: begin
                    if (de_i) begin
                        state_n       = ST_SEEK;
                        next_period_o = slip_val;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
                ST_SEEK: begin
                    cnt_n = cnt_q + CNT_W'(1);
                    if (!de_i) begin
                        state_n       = ST_LOCKED;
                        next_period_o = trim_val;
                    end else if (cnt_q == LAST) begin
                        state_n = ST_FAULT;
                    end else begin
                        next_period_o = slip_val;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            if (start_i) dir_q <= dir_i;
        end
    end

    assign flags.locked = (state_q == ST_LOCKED);
    assign flags.fault  = (state_q == ST_FAULT);
    assign locked_o     = flags.locked;
    assign fault_o      = flags.fault;
    assign line_cnt_o   = cnt_q;

    // Lock only ever appears right after a timer tick
    assert_lock_after_tick_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(tick_i));

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(locked_o && fault_o));

    assert_fault_count_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_o) |-> (line_cnt_o == CNT_W'(MAX_SEARCH)));

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!locked_o && !fault_o && line_cnt_o == '0));

endmodule

// File: rtl/raster_phase_lock.sv
module raster_phase_lock
    import rpl_pkg::*;
#(
    parameter int LINE_PERIOD = NOM_LINE,
    parameter int MAX_SEARCH  = SEEK_LIMIT,
    parameter int OFS_W       = OFFSET_W,
    localparam int PER_W      = $clog2(LINE_PERIOD + 2**(OFS_W-1) + 1),
    localparam int CNT_W      = $clog2(MAX_SEARCH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    de_i,
    input  logic                    dir_i,
    input  logic signed [OFS_W-1:0] ofs_i,
    output logic                    tick_o,
    output logic                    locked_o,
    output logic                    fault_o,
    output logic [CNT_W-1:0]        line_cnt_o
);

    logic [PER_W-1:0] reload;

    rpl_interval_timer #(
        .LINE_PERIOD(LINE_PERIOD),
        .PER_W      (PER_W)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load_i(reload),
        .tick_o(tick_o)
    );

    rpl_seek_ctrl #(
        .LINE_PERIOD(LINE_PERIOD),
        .MAX_SEARCH (MAX_SEARCH),
        .OFS_W      (OFS_W),
        .PER_W      (PER_W),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .tick_i       (tick_o),
        .de_i         (de_i),
        .dir_i        (dir_i),
        .ofs_i        (ofs_i),
        .next_period_o(reload),
        .locked_o     (locked_o),
        .fault_o      (fault_o),
        .line_cnt_o   (line_cnt_o)
    );

endmodule

// File: tb/raster_phase_lock_test.sv
`timescale 1ns/100ps
module raster_phase_lock_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       dir_i = 1'b0;
    logic [7:0] ofs_i = 8'd0;
    logic       de_i;
    logic       tick_o, locked_o, fault_o;
    logic [6:0] line_cnt_o;

    int cyc = 0, hpos = 0, act_w = 40;
    int tick_num = 0, last_tick = 0, gap = 0, tick_h = 0;
    bit tick_de = 1'b0;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    raster_phase_lock uut (
        .clk(clk), .rst(rst), .start_i(start_i), .de_i(de_i), .dir_i(dir_i),
        .ofs_i(ofs_i), .tick_o(tick_o), .locked_o(locked_o), .fault_o(fault_o),
        .line_cnt_o(line_cnt_o)
    );

    // Raster model: 76-clock line, active while position is below act_w
    assign de_i = (hpos < act_w);
    always @(posedge clk) begin
        cyc = cyc + 1;
        #1 hpos = (hpos + 1) % 76;
    end

    // Tick monitor: interval and raster position at each tick
    always @(negedge clk) begin
        if (!rst && tick_o) begin
            gap       = cyc - last_tick;
            last_tick = cyc;
            tick_h    = hpos;
            tick_de   = de_i;
            tick_num  = tick_num + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic next_tick();
        int n = tick_num;
        wait (tick_num > n);
        #1;
    endtask

    task automatic pulse_start(input bit dir, input int act, input int ofs);
        @(negedge clk);
        act_w   = act;
        dir_i   = dir;
        ofs_i   = 8'(ofs);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        chk("R10 locked cleared by start", int'(locked_o), 0);
        chk("R10 fault cleared by start", int'(fault_o), 0);
    endtask

    function automatic int expected_steps(input bit dir, input int act, input int h0);
        return dir ? (act - h0) : (h0 + 1);
    endfunction

    task automatic run_case(input bit dir, input int act, input int ofs);
        int h0, per, k, exp, p1;
        pulse_start(dir, act, ofs);
        next_tick();
        chk("R2 interval before arming tick", gap, 76);
        if (!tick_de) begin
            next_tick();
            chk("R3 ignored start keeps period", gap, 76);
            chk("R3 ignored start locked", int'(locked_o), 0);
            chk("R3 ignored start fault", int'(fault_o), 0);
            chk("R3 ignored start count", int'(line_cnt_o), 0);
            return;
        end
        h0  = tick_h;
        per = dir ? 77 : 75;
        exp = (act >= 76) ? 76 : expected_steps(dir, act, h0);
        k   = 0;
        forever begin
            next_tick();
            k++;
            if (dir) chk("R5 later search interval", gap, per);
            else     chk("R4 earlier search interval", gap, per);
            chk("R6 not locked during search", int'(locked_o), 0);
            if (!tick_de || k == 76) break;
        end
        @(negedge clk);
        #1;
        if (act >= 76) begin
            chk("R9 search length at fault", k, 76);
            chk("R9 fault flag", int'(fault_o), 1);
            chk("R9 count at fault", int'(line_cnt_o), 76);
            chk("R9 not locked", int'(locked_o), 0);
            next_tick();
            chk("R9 period after fault", gap, 76);
            chk("R10 fault holds", int'(fault_o), 1);
        end else begin
            chk("R7 edge tick index", k, exp);
            chk("R6 locked after edge tick", int'(locked_o), 1);
            chk("R7 line count at lock", int'(line_cnt_o), exp);
            p1 = 76 + ofs;
            if (p1 < 2) p1 = 2;
            next_tick();
            chk("R8 first interval after lock", gap, p1);
            next_tick();
            chk("R6 nominal interval after lock", gap, 76);
            chk("R10 locked holds", int'(locked_o), 1);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog (all R): got %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7391));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset locked", int'(locked_o), 0);
        chk("R1 reset fault", int'(fault_o), 0);
        chk("R1 reset count", int'(line_cnt_o), 0);
        next_tick();
        next_tick();
        chk("R1 free-running period", gap, 76);

        run_case(1'b0, 40, 0);
        run_case(1'b1, 40, 3);
        run_case(1'b0, 76, 0);
        run_case(1'b1, 0, 0);
        run_case(1'b0, 50, -100);
        run_case(1'b1, 60, 127);

        // Restart in the middle of a search
        pulse_start(1'b0, 76, 0);
        next_tick();
        repeat (5) next_tick();
        pulse_start(1'b1, 0, 0);
        next_tick();
        next_tick();
        chk("R10 restart count cleared", int'(line_cnt_o), 0);
        chk("R3 restart ignored period", gap, 76);

        for (int i = 0; i < 14; i++) begin
            repeat ($urandom % 90) @(negedge clk);
            run_case(1'($urandom % 2), 8 + int'($urandom % 60), int'($urandom % 21) - 10);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule